// File: doc/BRIEF.md
# Destructive Self-Reference Bit Read Sequencer

This block sequences one bit read in a magnetic memory cell where four storage elements sit behind a single access transistor. A plain compare against a reference cell does not work for this cell, so the bit is read by disturbing it. The block senses the cell once and then forces the addressed element to one. It senses again against an offset reference and decides the bit from whether the second sense dropped. If the bit turns out to have been zero, the block puts the zero back.

Each of the four steps is a memory phase of `PHASE_CLKS` clocks. With the default of four clocks on a 200 MHz clock, each phase lasts one 50 MHz memory cycle. The block drives the read word line, the per-element write word lines with their data polarity, and the sample and share strobes of the sense amplifier. It also drives the comparator latch strobe. The analog comparator result comes back on a single input. A requester hands over an address with a valid/ready handshake. The decided bit is returned with a one-clock valid pulse as soon as the second sense completes, while the restore is still running.

Top module: `sr_read_seq`

## Requirements
- R1: A synchronous active-low reset puts the block idle at the next clock edge: `req_ready` high, and `rd_line`, `wr_line`, `wr_one`, `smp_strobe`, `shr_strobe`, `cmp_latch` and `rd_valid` all low. This holds even partway through a sequence.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for exactly 4×`PHASE_CLKS` clocks and is high again on the following clock. `req_valid` has no effect while `req_ready` is low.
- R3: After acceptance the phases run in a fixed order, each lasting `PHASE_CLKS` clocks: first sense, force-one, second sense, restore. `rd_line` is high for the whole of both sense phases and low at all other times.
- R4: During the force-one phase, only `wr_line[e]` is high, where e is address bits [1:0], and `wr_one` is high. This is the same whatever the stored bit is. `wr_one` is low in every other phase.
- R5: At most one `wr_line` bit is high at any time, and `wr_line` is never high together with `rd_line`.
- R6: In the first sense phase, `smp_strobe` is high for phase clocks 0 to `PHASE_CLKS`-3, low on clock `PHASE_CLKS`-2, and `shr_strobe` is high only on clock `PHASE_CLKS`-1. The two strobes are never high together, and neither is high outside this phase.
- R7: `cmp_latch` is high only on the last clock of the second sense phase. The bit is decided at that edge: 0 when `sense_below_ref` is 1, and 1 when it is 0. The value of `sense_below_ref` at any other time has no effect.
- R8: `rd_valid` is a one-clock pulse on the first clock of the restore phase, and `rd_bit` carries the decided bit during that pulse.
- R9: In the restore phase, a decided 0 drives `wr_line[e]` high with `wr_one` low for all `PHASE_CLKS` clocks. A decided 1 leaves `wr_line` all zero.
- R10: `row_sel` shows address bits [ADDR_W-1:2] of the accepted request and stays unchanged for the whole sequence, whatever `req_addr` does after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Bit address; bits [1:0] pick the element |
| sense_below_ref | input | 1 | Comparator result: sense node below offset reference |
| row_sel | output | ADDR_W-2 | Captured upper address bits for row/column selection |
| rd_line | output | 1 | Read word line |
| wr_line | output | ELEMS | Per-element write word lines |
| wr_one | output | 1 | Write polarity: 1 writes one, 0 writes zero |
| smp_strobe | output | 1 | Sense amplifier sample phase |
| shr_strobe | output | 1 | Sense amplifier charge-share phase |
| cmp_latch | output | 1 | Comparator latch strobe |
| rd_valid | output | 1 | One-clock pulse: decided bit available |
| rd_bit | output | 1 | Decided bit |

## Verification
Outputs are compared on the falling edge. Counting is from the rising edge that accepts a request, so the first falling edge after it is sequence clock 0. Every line and strobe is checked against its expected value on every clock from 0 to 4×`PHASE_CLKS`-1. The `rd_valid` pulse is due on clock 3×`PHASE_CLKS`, and `req_ready` must return one clock after the last of these. The comparator input is held at the wrong value until the falling edge just before the deciding edge, and `req_addr` is changed right after acceptance. This shows that only the latch clock and the captured address count. A scoreboard queue holds the expected bit and row for each accepted request, and a monitor compares them on each `rd_valid`.

// File: rtl/sr_read_pkg.sv
package sr_read_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SENSE1,
      PH_FORCE1,
      PH_SENSE2,
      PH_RESTORE
   } phase_e;
endpackage

// File: rtl/sr_phase_timer.sv
module sr_phase_timer
   import sr_read_pkg::*;
#(
   parameter int PHASE_CLKS = 4,
   localparam int TW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output phase_e        phase,
   output logic [TW-1:0] tick
);
   localparam logic [TW-1:0] LAST_TICK = TW'(PHASE_CLKS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tick  <= '0;
      end else if (phase == PH_IDLE) begin
         tick <= '0;
         if (start) phase <= PH_SENSE1;
      end else if (tick == LAST_TICK) begin
         tick <= '0;
         case (phase)
            PH_SENSE1: phase <= PH_FORCE1;
            PH_FORCE1: phase <= PH_SENSE2;
            PH_SENSE2: phase <= PH_RESTORE;
            default:   phase <= PH_IDLE;
         endcase
      end else begin
         tick <= tick + 1'b1;
      end
   end
endmodule

// File: rtl/sr_line_decode.sv
module sr_line_decode
   import sr_read_pkg::*;
#(
   parameter int ELEMS      = 4,
   parameter int PHASE_CLKS = 4,
   parameter bit SHARE_GAP  = 1'b1,
   localparam int EW = $clog2(ELEMS),
   localparam int TW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1
) (
   input  phase_e           phase,
   input  logic [TW-1:0]    tick,
   input  logic [EW-1:0]    elem,
   input  logic             bit_q,
   output logic             rd_line,
   output logic [ELEMS-1:0] wr_line,
   output logic             wr_one,
   output logic             smp_strobe,
   output logic             shr_strobe,
   output logic             cmp_latch
);
   localparam logic [TW-1:0] LAST_TICK = TW'(PHASE_CLKS - 1);
   localparam int            SMP_END   = SHARE_GAP ? PHASE_CLKS - 2 : PHASE_CLKS - 1;
   localparam logic [TW-1:0] SMP_LIM   = TW'(SMP_END);

   logic last_tick;
   logic write_en;

   assign last_tick  = (tick == LAST_TICK);
   assign rd_line    = (phase == PH_SENSE1) || (phase == PH_SENSE2);
   assign write_en   = (phase == PH_FORCE1) || ((phase == PH_RESTORE) && !bit_q);
   assign wr_one     = (phase == PH_FORCE1);
   assign shr_strobe = (phase == PH_SENSE1) && last_tick;
   assign cmp_latch  = (phase == PH_SENSE2) && last_tick;
   assign smp_strobe = (phase == PH_SENSE1) && (tick < SMP_LIM);

   for (genvar e = 0; e < ELEMS; e++) begin : g_wl
      assign wr_line[e] = write_en && (elem == EW'(e));
   end
endmodule

// File: rtl/sr_bit_decide.sv
module sr_bit_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_latch,
   input  logic sense_below_ref,
   output logic bit_q,
   output logic valid_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= cmp_latch;
         if (cmp_latch) bit_q <= !sense_below_ref;
      end
   end
endmodule

// File: rtl/sr_read_seq.sv
module sr_read_seq
   import sr_read_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int ELEMS      = 4,
   parameter int PHASE_CLKS = 4,
   parameter bit SHARE_GAP  = 1'b1,
   localparam int EW    = $clog2(ELEMS),
   localparam int ROW_W = ADDR_W - EW,
   localparam int TW    = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic             sense_below_ref,
   output logic [ROW_W-1:0] row_sel,
   output logic             rd_line,
   output logic [ELEMS-1:0] wr_line,
   output logic             wr_one,
   output logic             smp_strobe,
   output logic             shr_strobe,
   output logic             cmp_latch,
   output logic             rd_valid,
   output logic             rd_bit
);
   if (ELEMS < 2 || (ELEMS & (ELEMS - 1)) != 0) begin : g_bad_elems
      $error("ELEMS must be a power of two of at least 2");
   end
   if (PHASE_CLKS < (SHARE_GAP ? 3 : 2)) begin : g_bad_phase
      $error("PHASE_CLKS too short for the strobe pattern");
   end
   if (ADDR_W <= EW) begin : g_bad_addr
      $error("ADDR_W must exceed the element select width");
   end

   phase_e            phase;
   logic [TW-1:0]     tick;
   logic [ADDR_W-1:0] addr_q;
   logic              accept;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign row_sel   = addr_q[ADDR_W-1:EW];

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= req_addr;
   end

   sr_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .phase (phase),
      .tick  (tick)
   );

   sr_line_decode #(
      .ELEMS      (ELEMS),
      .PHASE_CLKS (PHASE_CLKS),
      .SHARE_GAP  (SHARE_GAP)
   ) u_lines (
      .phase      (phase),
      .tick       (tick),
      .elem       (addr_q[EW-1:0]),
      .bit_q      (rd_bit),
      .rd_line    (rd_line),
      .wr_line    (wr_line),
      .wr_one     (wr_one),
      .smp_strobe (smp_strobe),
      .shr_strobe (shr_strobe),
      .cmp_latch  (cmp_latch)
   );

   sr_bit_decide u_decide (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmp_latch       (cmp_latch),
      .sense_below_ref (sense_below_ref),
      .bit_q           (rd_bit),
      .valid_q         (rd_valid)
   );
endmodule

// File: rtl/sr_read_seq_chk.sv
module sr_read_seq_chk #(
   parameter int ELEMS = 4,
   parameter int ROW_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic [ROW_W-1:0] row_sel,
   input logic             rd_line,
   input logic [ELEMS-1:0] wr_line,
   input logic             wr_one,
   input logic             smp_strobe,
   input logic             shr_strobe,
   input logic             rd_valid,
   input logic             rd_bit
);
   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_strobe && shr_strobe));

   // R5
   wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_line));

   // R5
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_line && (wr_line != '0)));

   // R4
   force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_one |-> ($countones(wr_line) == 1));

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R2
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !req_ready);

   // R9
   restore_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_bit) |-> (wr_line == '0));

   // R9
   restore_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_bit) |-> ((wr_line != '0) && !wr_one));

   // R10
   row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(row_sel));
endmodule

bind sr_read_seq sr_read_seq_chk #(.ELEMS(ELEMS), .ROW_W(ROW_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .row_sel    (row_sel),
   .rd_line    (rd_line),
   .wr_line    (wr_line),
   .wr_one     (wr_one),
   .smp_strobe (smp_strobe),
   .shr_strobe (shr_strobe),
   .rd_valid   (rd_valid),
   .rd_bit     (rd_bit)
);

// File: tb/sr_read_seq_tb.sv
module sr_read_seq_tb;
   localparam int ADDR_W = 16;
   localparam int ELEMS  = 4;
   localparam int PC     = 4;
   localparam int ROW_W  = ADDR_W - 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic             sense_below_ref = 1'b0;
   logic [ROW_W-1:0] row_sel;
   logic             rd_line;
   logic [ELEMS-1:0] wr_line;
   logic             wr_one, smp_strobe, shr_strobe, cmp_latch, rd_valid, rd_bit;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   logic [ROW_W:0] sb_q[$];   // {bit, row}

   always #2.5 clk = ~clk;

   sr_read_seq #(.ADDR_W(ADDR_W), .ELEMS(ELEMS), .PHASE_CLKS(PC), .SHARE_GAP(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .sense_below_ref(sense_below_ref), .row_sel(row_sel),
      .rd_line(rd_line), .wr_line(wr_line), .wr_one(wr_one), .smp_strobe(smp_strobe),
      .shr_strobe(shr_strobe), .cmp_latch(cmp_latch), .rd_valid(rd_valid), .rd_bit(rd_bit)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [10:0] outs();
      return {req_ready, rd_line, wr_line, wr_one, smp_strobe, shr_strobe, cmp_latch, rd_valid};
   endfunction

   task automatic chk_idle(input string req);
      chk(outs() == 11'b100_0000_0000, req, "idle outputs", 32'(outs()), 32'h400);
   endtask

   // Driver: one read; expected bit is 0 when the comparator reports below-reference
   task automatic do_read(input logic [ADDR_W-1:0] addr, input logic below, input bit hold_valid);
      logic [1:0]       e;
      logic [ROW_W-1:0] row;
      e   = addr[1:0];
      row = addr[ADDR_W-1:2];
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid       = 1'b1;
      req_addr        = addr;
      sense_below_ref = !below;               // wrong value until the latch clock (R7)
      sb_q.push_back({!below, row});
      @(posedge clk);
      #1;
      req_addr  = ~addr;                      // R10: later address changes ignored
      req_valid = hold_valid;                 // R2: valid while busy ignored
      for (int t = 0; t < 4 * PC; t++) begin
         int ph, tk;
         logic [10:0] exp;
         logic [ELEMS-1:0] wl;
         string req;
         @(negedge clk);
         ph = t / PC;
         tk = t % PC;
         wl = '0;
         if (ph == 1 || (ph == 3 && below)) wl[e] = 1'b1;
         exp = {1'b0, (ph == 0 || ph == 2), wl, (ph == 1),
                (ph == 0 && tk < PC - 2), (ph == 0 && tk == PC - 1),
                (ph == 2 && tk == PC - 1), (t == 3 * PC)};
         case (ph)
            0: req = "R3 R6";
            1: req = "R4 R5";
            2: req = "R3 R7";
            default: req = "R8 R9";
         endcase
         chk(outs() == exp, req, $sformatf("lines at seq clock %0d", t), 32'(outs()), 32'(exp));
         chk(row_sel == row, "R10", "row_sel held", 32'(row_sel), 32'(row));
         if (t == 3 * PC - 1) sense_below_ref = below;
      end
      @(negedge clk);
      chk_idle("R2");
      req_valid = 1'b0;
   endtask

   // Monitor: scoreboard compare on each result pulse
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected rd_valid", 32'(rd_bit), 32'h0);
         end else begin
            logic [ROW_W:0] item;
            item = sb_q.pop_front();
            chk(rd_bit == item[ROW_W], "R7", "decided bit", 32'(rd_bit), 32'(item[ROW_W]));
            chk(row_sel == item[ROW_W-1:0], "R10", "row at result", 32'(row_sel), 32'(item[ROW_W-1:0]));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_idle("R1");                         // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");

      do_read(16'h0001, 1'b1, 1'b0);
      do_read(16'h1232, 1'b0, 1'b0);
      do_read(16'hFFFF, 1'b1, 1'b1);
      do_read(16'h8000, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         do_read(ADDR_W'(16'h5A50 + i * 16'h0111 + (i % 4)), logic'(i[0] ^ i[2]), bit'(i[1]));
      end

      // R1: reset in the middle of a sequence
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 16'h0042;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      repeat (PC + 2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");

      do_read(16'hC003, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R8", "all results returned", 32'(sb_q.size()), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule